// File: doc/BRIEF.md
# Yes/No Branching Step Controller

This block is an eight-step sequence controller in which every step tests exactly one condition input. The current step number selects its condition. When that condition is true, the controller pulls the step's primary function line low and moves to the next step. The last step wraps back to the first.

A subset of the steps are branch steps. In a branch step, a false condition pulls that step's secondary function line low instead. The secondary lines feed a small encoder that forms a fixed jump target. On the next clock edge, the state register loads that target in place of incrementing. In the other steps, a false condition leaves every function line inactive and the controller waits.

The selected condition gates the two function decoders in opposite senses, so at most one function line is active at any time. The branch steps and their targets are parameters. By default the branches are step 1 to 4, step 3 to 6, step 5 to 6 and step 7 to 0.

Top module: `branch_seq_ctrl`

## Requirements
- R1: While rst_ni is low, the step is 0: with cond_i[0]=1 only prim_fn_no_o[0] is low, and with cond_i[0]=0 all function outputs are high.
- R2: In step k, when cond_i[k]=1, prim_fn_no_o[k] is the only low output. The next edge moves to step k+1, and step 7 moves to step 0.
- R3: In steps 0, 2, 4 and 6, when cond_i[k]=0, all outputs of both buses are high and the step is unchanged on the next edge.
- R4: In step 1, when cond_i[1]=0, sec_fn_no_o[1] is the only low output and the next step is 4.
- R5: In step 3, when cond_i[3]=0, sec_fn_no_o[3] is the only low output and the next step is 6.
- R6: In step 5, when cond_i[5]=0, sec_fn_no_o[5] is the only low output and the next step is 6.
- R7: In step 7, when cond_i[7]=0, sec_fn_no_o[7] is the only low output and the next step is 0.
- R8: At most one of the 16 function outputs is low at any time. sec_fn_no_o bits 0, 2, 4 and 6 are always high.
- R9: Only cond_i[k] of the current step k affects the outputs and the next step; the other condition bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset to step 0 |
| cond_i | input | 8 | Condition inputs, bit k tested in step k |
| prim_fn_no_o | output | 8 | Active-low primary functions, bit k for step k |
| sec_fn_no_o | output | 8 | Active-low secondary functions, bit k for branch step k |

## Verification
The bench builds the block with its default parameters:
- eight steps;
- branch mask 8'b1010_1010;
- targets 4, 6, 6 and 0.

These values bring within reach the wrap from step 7 to 0 by incrementing, and the jump from step 7 to 0 by loading. They also cover two branch steps that share target 6, and a backward jump. Condition patterns that set every non-selected bit give the controller a chance to react to the wrong input, and the bench checks that it does not.

// File: rtl/branch_ctrl_pkg.sv
package branch_ctrl_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } step_act_e;
endpackage

// File: rtl/cond_select.sv
module cond_select #(
  parameter int N_STATES = 8,
  parameter int STATE_W  = $clog2(N_STATES)
) (
  input  logic [STATE_W-1:0]  sel_i,
  input  logic [N_STATES-1:0] cond_i,
  output logic                hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < N_STATES; k++) begin
      if (sel_i == STATE_W'(k)) hit_o = cond_i[k];
    end
  end
endmodule

// File: rtl/fn_decoder.sv
module fn_decoder #(
  parameter int                N_STATES = 8,
  parameter int                STATE_W  = $clog2(N_STATES),
  parameter logic [N_STATES-1:0] MASK   = '1
) (
  input  logic                en_i,
  input  logic [STATE_W-1:0]  addr_i,
  output logic [N_STATES-1:0] fn_no_o
);
  for (genvar k = 0; k < N_STATES; k++) begin : g_line
    if (MASK[k]) begin : g_used
      assign fn_no_o[k] = ~(en_i && (addr_i == STATE_W'(k)));
    end else begin : g_tied
      assign fn_no_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/jump_encoder.sv
module jump_encoder #(
  parameter int                          N_STATES = 8,
  parameter int                          STATE_W  = $clog2(N_STATES),
  parameter logic [N_STATES*STATE_W-1:0] JUMP_TGT = '0
) (
  input  logic [N_STATES-1:0] sec_fn_no_i,
  output logic                load_o,
  output logic [STATE_W-1:0]  addr_o
);
  // target bits are wired-OR of active secondary lines
  always_comb begin
    load_o = 1'b0;
    addr_o = '0;
    for (int k = 0; k < N_STATES; k++) begin
      if (!sec_fn_no_i[k]) begin
        load_o = 1'b1;
        addr_o = addr_o | JUMP_TGT[k*STATE_W +: STATE_W];
      end
    end
  end
endmodule

// File: rtl/state_counter.sv
module state_counter
  import branch_ctrl_pkg::*;
#(
  parameter int N_STATES = 8,
  parameter int STATE_W  = $clog2(N_STATES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               inc_i,
  input  logic [STATE_W-1:0] load_addr_i,
  output logic [STATE_W-1:0] state_o
);
  localparam logic [STATE_W-1:0] LAST = STATE_W'(N_STATES - 1);

  step_act_e           act;
  logic [STATE_W-1:0]  state_q;
  logic [STATE_W-1:0]  state_d;

  // load wins over increment
  always_comb begin
    if (load_i)     act = ACT_LOAD;
    else if (inc_i) act = ACT_STEP;
    else            act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: state_d = load_addr_i;
      ACT_STEP: state_d = (state_q == LAST) ? '0 : state_q + 1'b1;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/branch_seq_ctrl.sv
module branch_seq_ctrl #(
  parameter int                          N_STATES = 8,
  parameter int                          STATE_W  = $clog2(N_STATES),
  parameter logic [N_STATES-1:0]         SEC_MASK = 8'b1010_1010,
  parameter logic [N_STATES*STATE_W-1:0] JUMP_TGT = 24'b000_000_110_000_110_000_100_000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STATES-1:0] cond_i,
  output logic [N_STATES-1:0] prim_fn_no_o,
  output logic [N_STATES-1:0] sec_fn_no_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] jump_addr;
  logic               cond_hit;
  logic               jump_load;

  cond_select #(.N_STATES(N_STATES), .STATE_W(STATE_W)) i_cond_select (
    .sel_i  (state_q),
    .cond_i (cond_i),
    .hit_o  (cond_hit)
  );

  fn_decoder #(.N_STATES(N_STATES), .STATE_W(STATE_W), .MASK('1)) i_prim_dec (
    .en_i    (cond_hit),
    .addr_i  (state_q),
    .fn_no_o (prim_fn_no_o)
  );

  fn_decoder #(.N_STATES(N_STATES), .STATE_W(STATE_W), .MASK(SEC_MASK)) i_sec_dec (
    .en_i    (~cond_hit),
    .addr_i  (state_q),
    .fn_no_o (sec_fn_no_o)
  );

  jump_encoder #(.N_STATES(N_STATES), .STATE_W(STATE_W), .JUMP_TGT(JUMP_TGT)) i_jump_enc (
    .sec_fn_no_i (sec_fn_no_o),
    .load_o      (jump_load),
    .addr_o      (jump_addr)
  );

  state_counter #(.N_STATES(N_STATES), .STATE_W(STATE_W)) i_state_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (jump_load),
    .inc_i       (cond_hit),
    .load_addr_i (jump_addr),
    .state_o     (state_q)
  );
endmodule

// File: rtl/branch_seq_ctrl_chk.sv
module branch_seq_ctrl_chk #(
  parameter int                          N_STATES = 8,
  parameter int                          STATE_W  = $clog2(N_STATES),
  parameter logic [N_STATES-1:0]         SEC_MASK = '0,
  parameter logic [N_STATES*STATE_W-1:0] JUMP_TGT = '0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [STATE_W-1:0]  state_i,
  input logic [N_STATES-1:0] prim_fn_no_i,
  input logic [N_STATES-1:0] sec_fn_no_i
);
  localparam logic [STATE_W-1:0] LAST = STATE_W'(N_STATES - 1);

  // R8
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~{prim_fn_no_i, sec_fn_no_i}));

  // R8
  a_r8_unused_sec_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_fn_no_i | SEC_MASK) == {N_STATES{1'b1}});

  // R2
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_fn_no_i != {N_STATES{1'b1}}) |=>
      (state_i == (($past(state_i) == LAST) ? '0 : $past(state_i) + 1'b1)));

  // R3
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_fn_no_i == {N_STATES{1'b1}} && sec_fn_no_i == {N_STATES{1'b1}}) |=>
      $stable(state_i));

  // R4 R5 R6 R7: each branch step loads its own target
  for (genvar k = 0; k < N_STATES; k++) begin : g_jump
    if (SEC_MASK[k]) begin : g_on
      a_r4_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sec_fn_no_i[k] |=> (state_i == JUMP_TGT[k*STATE_W +: STATE_W]));
    end
  end
endmodule

bind branch_seq_ctrl branch_seq_ctrl_chk #(
  .N_STATES (N_STATES),
  .STATE_W  (STATE_W),
  .SEC_MASK (SEC_MASK),
  .JUMP_TGT (JUMP_TGT)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .prim_fn_no_i (prim_fn_no_o),
  .sec_fn_no_i  (sec_fn_no_o)
);

// File: tb/test_branch_seq_ctrl.sv
module test_branch_seq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cond_i = 8'h00;
  logic [7:0] prim_fn_no_o;
  logic [7:0] sec_fn_no_o;

  typedef struct {
    logic [7:0] prim;
    logic [7:0] sec;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  int   st = 0;

  always #2 clk_i = ~clk_i;

  branch_seq_ctrl i_branch_seq_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cond_i       (cond_i),
    .prim_fn_no_o (prim_fn_no_o),
    .sec_fn_no_o  (sec_fn_no_o)
  );

  function automatic int tgt_of(int s);
    case (s)
      1: return 4;
      3: return 6;
      5: return 6;
      7: return 0;
      default: return s;
    endcase
  endfunction

  // drive at negedge, push expectation, advance model at the coming posedge
  task automatic step(input logic [7:0] c, input string tag);
    exp_t e;
    @(negedge clk_i);
    cond_i = c;
    e.prim = 8'hFF;
    e.sec  = 8'hFF;
    e.tag  = tag;
    if (c[st]) begin
      e.prim[st] = 1'b0;
      if (rst_ni) st = (st + 1) % 8;
    end else if (st % 2 == 1) begin
      e.sec[st] = 1'b0;
      if (rst_ni) st = tgt_of(st);
    end
    q.push_back(e);
  endtask

  function automatic logic [7:0] hit(int s);
    return 8'h01 << s;
  endfunction

  function automatic logic [7:0] miss(int s);
    return ~(8'h01 << s);
  endfunction

  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (prim_fn_no_o !== e.prim || sec_fn_no_o !== e.sec) begin
          failures++;
          $display("FAIL %s prim=%h sec=%h expected prim=%h sec=%h",
                   e.tag, prim_fn_no_o, sec_fn_no_o, e.prim, e.sec);
        end
      end
    end
  end

  initial begin
    // R1: reset holds step 0 whatever the conditions
    step(8'hFF, "R1");
    step(8'hFE, "R1");
    step(8'h01, "R1");
    step(8'h00, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(8'h00, "R1");
    // R3 hold in step 0, R9 others set
    step(miss(0), "R9");
    step(8'h00, "R3");
    // R2 full increment walk with wrap 7 -> 0
    for (int k = 0; k < 8; k++) step(hit(k), "R2");
    step(8'hFF, "R2");          // step 0 -> 1, R9 others set
    // R4 step 1 false -> 4
    step(miss(1), "R4");
    step(miss(4), "R3");        // hold at 4, R9
    step(8'h00, "R3");
    step(hit(4), "R2");         // -> 5
    // R6 step 5 false -> 6
    step(miss(5), "R6");
    step(8'h00, "R3");          // hold at 6
    step(miss(6), "R9");
    step(8'hFF, "R2");          // -> 7
    // R7 step 7 false -> 0
    step(miss(7), "R7");
    step(hit(0), "R2");         // -> 1
    step(8'hFF, "R2");          // -> 2
    step(miss(2), "R3");        // hold at 2
    step(hit(2), "R2");         // -> 3
    // R5 step 3 false -> 6
    step(8'h00, "R5");
    step(hit(6), "R2");         // -> 7
    step(8'h00, "R7");          // -> 0
    // R8 alternate patterns
    step(8'h55, "R8");          // 0 -> 1
    step(8'h55, "R8");          // step 1 false -> 4
    step(8'hAA, "R8");          // hold at 4
    step(8'h10, "R8");          // -> 5
    step(8'hDF, "R8");          // step 5 false -> 6
    step(8'h40, "R8");          // -> 7
    step(8'h80, "R8");          // wrap -> 0
    step(8'h00, "R8");
    @(negedge clk_i);
    @(negedge clk_i);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule